// File: doc/BRIEF.md
# Group-Indexed Protection Vector Cache

This block is a small direct-mapped cache of access-protection vector words placed in front of a transfer path. Every lookup carries a 3-bit group identifier and a physical address. One cycle after it is accepted, the block reports hit or miss and, on a hit, the cached vector word. After a miss, the surrounding logic fetches the vector from memory and writes it in through the fill port. Memory fetch, bus handling and the decoding of permission bits are done elsewhere.

A configuration bit selects how the set index is formed. With group-set indexing on, the index is the group identifier with one address bit above it. This gives the sets of each group fixed places in the array. With it off, the index is taken only from address bits. Every line stores its full upper address and its group, so a hit never depends on the indexing mode.

A flush port takes a command to invalidate the whole array or only the sets of one group. A flush walks the sets one per clock cycle. While it runs, the stall output is held high, and lookups and fills are not accepted.

Top module: `prot_vec_cache`

## Requirements
- R1: After reset, `stall` and `rsp_valid` are low, and the first lookup of any address misses.
- R2: A lookup presented while `stall` is low is accepted. In the next cycle `rsp_valid` is high and `rsp_hit` shows whether a valid line matched. On a hit, `rsp_vec` carries the filled word. On a miss, `rsp_vec` is zero.
- R3: A hit requires that the stored address bits from `IDX_LSB` upward and the stored group both equal those of the lookup. A lookup that differs in either one misses.
- R4: With `cfg_grp_mode`=1, the 4-bit set index is {addr[IDX_LSB], grp[2:0]}, so equal addresses in different groups occupy different sets. With `cfg_grp_mode`=0, the index is addr[IDX_LSB+3:IDX_LSB], so a fill replaces the line held at that set whatever its group.
- R5: An accepted flush with `fl_all`=1 drives `stall` high from the next cycle for exactly 16 cycles and invalidates every set.
- R6: An accepted flush with `fl_all`=0 and group g drives `stall` high for exactly 2 cycles. It invalidates only sets {0,g} and {1,g}, and lines in all other sets still hit.
- R7: While `stall` is high, lookups are not accepted, and `rsp_valid` stays low in the following cycle.
- R8: A fill presented while `stall` is high is dropped, and a later lookup of that line misses.
- R9: A flush request presented while `stall` is high is ignored and does not lengthen the running flush.
- R10: A group flush with `cfg_grp_mode`=0 still clears only the sets whose low three index bits equal g. A line of group g held in another set survives and still hits.
- R11: A lookup and a fill to the same set in the same cycle return the contents from before the fill. The filled line hits from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_grp_mode | input | 1 | 1 = group-set indexing, 0 = address-only indexing |
| lk_valid | input | 1 | Lookup request |
| lk_grp | input | GRP_W | Group of the lookup |
| lk_addr | input | ADDR_W | Physical address of the lookup |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_vec | output | VEC_W | Cached vector word on a hit, zero on a miss |
| fill_valid | input | 1 | Fill request |
| fill_grp | input | GRP_W | Group of the fill |
| fill_addr | input | ADDR_W | Physical address of the fill |
| fill_vec | input | VEC_W | Vector word to store |
| fl_valid | input | 1 | Flush request |
| fl_all | input | 1 | 1 = flush all sets, 0 = flush one group |
| fl_grp | input | GRP_W | Group to flush when `fl_all` is 0 |
| stall | output | 1 | Flush in progress; the transfer path must hold |

## Verification
The hardest case to reach is traffic that arrives in the middle of a flush walk. A fill, a lookup and a second flush request all have to be refused at once, and the refused fill must leave no trace afterwards. The bench starts a full flush and then, on every stall cycle, drives all three requests together. It checks that no response appears and that the stall lasts exactly 16 cycles, and then looks up the dropped fill to confirm that it misses. A second hard case is a group flush in address-only mode, where a surviving line of the same group must still hit. The bench places two lines of one group in sets that lie inside and outside the walk.

// File: rtl/pvc_pkg.sv
`timescale 1ns/1ps
package pvc_pkg;

    typedef enum logic {
        FLUSH_GROUP = 1'b0,
        FLUSH_ALL   = 1'b1
    } flush_kind_e;

endpackage

// File: rtl/pvc_index.sv
`timescale 1ns/1ps
module pvc_index #(
    parameter int ADDR_W  = 32,
    parameter int GRP_W   = 3,
    parameter int IDX_LSB = 5
) (
    input  logic              grp_mode,
    input  logic [GRP_W-1:0]  grp,
    input  logic [ADDR_W-1:0] addr,
    output logic [GRP_W:0]    idx
);
    localparam int IDX_W = GRP_W + 1;

    logic [IDX_W-1:0] idx_grp;
    logic [IDX_W-1:0] idx_flat;

    always_comb begin
        idx_grp  = {addr[IDX_LSB], grp};
        idx_flat = addr[IDX_LSB +: IDX_W];
        idx      = grp_mode ? idx_grp : idx_flat;
    end

endmodule

// File: rtl/pvc_flush_seq.sv
`timescale 1ns/1ps
module pvc_flush_seq
    import pvc_pkg::*;
#(
    parameter int GRP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_all,
    input  logic [GRP_W-1:0] req_grp,
    output logic             busy,
    output logic             clr_en,
    output logic [GRP_W:0]   clr_idx
);
    localparam int IDX_W = GRP_W + 1;
    localparam int HI_W  = IDX_W - GRP_W;
    localparam int SETS  = 1 << IDX_W;

    typedef struct packed {
        logic              busy;
        flush_kind_e       kind;
        logic [GRP_W-1:0]  grp;
        logic [IDX_W-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_set;

    always_comb begin
        seq_d   = seq_q;
        clr_en  = 1'b0;
        if (seq_q.kind == FLUSH_ALL) begin
            clr_idx  = seq_q.cnt;
            last_set = (seq_q.cnt == IDX_W'(SETS - 1));
        end else begin
            clr_idx  = {seq_q.cnt[HI_W-1:0], seq_q.grp};
            last_set = &seq_q.cnt[HI_W-1:0];
        end
        if (seq_q.busy) begin
            clr_en    = 1'b1;
            seq_d.cnt = seq_q.cnt + 1'b1;
            if (last_set) begin
                seq_d.busy = 1'b0;
            end
        end else if (req_valid) begin
            seq_d.busy = 1'b1;
            seq_d.kind = req_all ? FLUSH_ALL : FLUSH_GROUP;
            seq_d.grp  = req_grp;
            seq_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = seq_q.busy;

endmodule

// File: rtl/pvc_line_store.sv
`timescale 1ns/1ps
module pvc_line_store #(
    parameter int IDX_W  = 4,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line
);
    localparam int SETS = 1 << IDX_W;

    logic [LINE_W-1:0] lines_d [SETS];
    logic [LINE_W-1:0] lines_q [SETS];

    always_comb begin
        for (int i = 0; i < SETS; i++) begin
            lines_d[i] = lines_q[i];
        end
        if (wr_en) begin
            lines_d[wr_idx] = wr_line;
        end
        if (clr_en) begin
            lines_d[clr_idx] = '0;
        end
        rd_line = lines_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                lines_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SETS; i++) begin
                lines_q[i] <= lines_d[i];
            end
        end
    end

endmodule

// File: rtl/prot_vec_cache.sv
`timescale 1ns/1ps
module prot_vec_cache #(
    parameter int ADDR_W  = 32,
    parameter int VEC_W   = 32,
    parameter int GRP_W   = 3,
    parameter int IDX_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_grp_mode,
    input  logic              lk_valid,
    input  logic [GRP_W-1:0]  lk_grp,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [VEC_W-1:0]  rsp_vec,
    input  logic              fill_valid,
    input  logic [GRP_W-1:0]  fill_grp,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [VEC_W-1:0]  fill_vec,
    input  logic              fl_valid,
    input  logic              fl_all,
    input  logic [GRP_W-1:0]  fl_grp,
    output logic              stall
);
    localparam int IDX_W  = GRP_W + 1;
    localparam int TAG_W  = ADDR_W - IDX_LSB;
    localparam int LINE_W = 1 + GRP_W + TAG_W + VEC_W;

    typedef struct packed {
        logic              valid;
        logic [GRP_W-1:0]  grp;
        logic [TAG_W-1:0]  tag;
        logic [VEC_W-1:0]  vec;
    } line_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [VEC_W-1:0]  vec;
    } rsp_t;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fill_idx;
    logic [IDX_W-1:0] clr_idx;
    logic             clr_en;
    logic             busy;
    logic             fill_take;
    line_t            wr_line;
    line_t            rd_line;
    logic [LINE_W-1:0] rd_raw;
    rsp_t             rsp_d, rsp_q;

    pvc_index #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_LSB(IDX_LSB)) i_lk_index (
        .grp_mode (cfg_grp_mode),
        .grp      (lk_grp),
        .addr     (lk_addr),
        .idx      (lk_idx)
    );

    pvc_index #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_LSB(IDX_LSB)) i_fill_index (
        .grp_mode (cfg_grp_mode),
        .grp      (fill_grp),
        .addr     (fill_addr),
        .idx      (fill_idx)
    );

    pvc_flush_seq #(.GRP_W(GRP_W)) i_flush_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (fl_valid),
        .req_all   (fl_all),
        .req_grp   (fl_grp),
        .busy      (busy),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx)
    );

    always_comb begin
        fill_take     = fill_valid && !busy;
        wr_line.valid = 1'b1;
        wr_line.grp   = fill_grp;
        wr_line.tag   = fill_addr[ADDR_W-1:IDX_LSB];
        wr_line.vec   = fill_vec;
    end

    pvc_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) i_line_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_take),
        .wr_idx  (fill_idx),
        .wr_line (wr_line),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .rd_idx  (lk_idx),
        .rd_line (rd_raw)
    );

    always_comb begin
        rd_line     = line_t'(rd_raw);
        rsp_d.valid = lk_valid && !busy;
        rsp_d.hit   = rsp_d.valid && rd_line.valid
                      && (rd_line.grp == lk_grp)
                      && (rd_line.tag == lk_addr[ADDR_W-1:IDX_LSB]);
        rsp_d.vec   = rsp_d.hit ? rd_line.vec : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_vec   = rsp_q.vec;
    assign stall     = busy;

endmodule

// File: rtl/prot_vec_cache_chk.sv
`timescale 1ns/1ps
module prot_vec_cache_chk #(
    parameter int ADDR_W  = 32,
    parameter int VEC_W   = 32,
    parameter int GRP_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [VEC_W-1:0]  rsp_vec,
    input logic              fl_valid,
    input logic              fl_all,
    input logic              stall
);
    localparam int SETS  = 1 << (GRP_W + 1);
    localparam int CNT_W = GRP_W + 3;

    logic [CNT_W-1:0] run_q;
    logic             kind_all_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            kind_all_q <= 1'b0;
        end else begin
            run_q <= stall ? run_q + 1'b1 : '0;
            if (fl_valid && !stall) begin
                kind_all_q <= fl_all;
            end
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !stall) |=> rsp_valid);

    assert_hit_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_hit) |-> (rsp_vec == '0));

    assert_no_rsp_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(lk_valid) && !$past(stall)));

    assert_stall_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !stall) |=> stall);

    assert_group_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_all && !stall) |=> stall ##1 stall ##1 !stall);

    assert_walk_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (run_q == (kind_all_q ? CNT_W'(SETS) : CNT_W'(2))));

    assert_walk_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CNT_W'(SETS));

endmodule

bind prot_vec_cache prot_vec_cache_chk #(
    .ADDR_W (ADDR_W),
    .VEC_W  (VEC_W),
    .GRP_W  (GRP_W)
) i_prot_vec_cache_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_vec   (rsp_vec),
    .fl_valid  (fl_valid),
    .fl_all    (fl_all),
    .stall     (stall)
);

// File: tb/test_prot_vec_cache.sv
`timescale 1ns/1ps
module test_prot_vec_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_grp_mode = 1'b0;
    logic        lk_valid = 1'b0;
    logic [2:0]  lk_grp = '0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_vec;
    logic        fill_valid = 1'b0;
    logic [2:0]  fill_grp = '0;
    logic [31:0] fill_addr = '0;
    logic [31:0] fill_vec = '0;
    logic        fl_valid = 1'b0;
    logic        fl_all = 1'b0;
    logic [2:0]  fl_grp = '0;
    logic        stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prot_vec_cache i_prot_vec_cache (
        .clk, .rst_n, .cfg_grp_mode,
        .lk_valid, .lk_grp, .lk_addr,
        .rsp_valid, .rsp_hit, .rsp_vec,
        .fill_valid, .fill_grp, .fill_addr, .fill_vec,
        .fl_valid, .fl_all, .fl_grp,
        .stall
    );

    function automatic logic [31:0] vec_of(input logic [2:0] g, input logic [31:0] a);
        return {a[27:0], 1'b1, g} ^ 32'h5A00_0000;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [2:0] g, input logic [31:0] a, input logic hit, input string req);
        lk_valid = 1'b1; lk_grp = g; lk_addr = a;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(req, "rsp_hit", 64'(rsp_hit), 64'(hit));
        chk(req, "rsp_vec", 64'(rsp_vec), hit ? 64'(vec_of(g, a)) : 64'd0);
    endtask

    task automatic fill(input logic [2:0] g, input logic [31:0] a);
        fill_valid = 1'b1; fill_grp = g; fill_addr = a; fill_vec = vec_of(g, a);
        @(posedge clk); @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic flush(input logic all, input logic [2:0] g, input int exp_len, input string req);
        int n;
        fl_valid = 1'b1; fl_all = all; fl_grp = g;
        @(posedge clk); @(negedge clk);
        fl_valid = 1'b0;
        n = 0;
        while (stall && n < 40) begin
            n++;
            @(negedge clk);
        end
        chk(req, "stall length", 64'(n), 64'(exp_len));
    endtask

    task automatic t_reset();
        chk("R1", "stall after reset", 64'(stall), 64'd0);
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        cfg_grp_mode = 1'b1;
        lookup(3'd0, 32'h0000_1000, 1'b0, "R1");
    endtask

    task automatic t_group_index();
        cfg_grp_mode = 1'b1;
        fill(3'd1, 32'h0000_1000);
        fill(3'd2, 32'h0000_1000);
        lookup(3'd1, 32'h0000_1000, 1'b1, "R4 R2 group set 1");
        lookup(3'd2, 32'h0000_1000, 1'b1, "R4 R2 group set 2");
        lookup(3'd3, 32'h0000_1000, 1'b0, "R3 other group");
        lookup(3'd2, 32'h0000_3000, 1'b0, "R3 other address");
    endtask

    task automatic t_flat_index();
        cfg_grp_mode = 1'b0;
        flush(1'b1, 3'd0, 16, "R5");
        fill(3'd1, 32'h0000_1000);
        fill(3'd2, 32'h0000_1000);
        lookup(3'd1, 32'h0000_1000, 1'b0, "R4 flat evicted");
        lookup(3'd2, 32'h0000_1000, 1'b1, "R4 flat survivor");
    endtask

    task automatic t_same_cycle();
        cfg_grp_mode = 1'b1;
        fill_valid = 1'b1; fill_grp = 3'd5; fill_addr = 32'h0000_2000; fill_vec = vec_of(3'd5, 32'h0000_2000);
        lookup(3'd5, 32'h0000_2000, 1'b0, "R11 old contents");
        fill_valid = 1'b0;
        lookup(3'd5, 32'h0000_2000, 1'b1, "R11 after fill");
    endtask

    task automatic t_full_flush();
        cfg_grp_mode = 1'b1;
        fill(3'd0, 32'h0000_1000);
        fill(3'd7, 32'h0000_1020);
        lookup(3'd7, 32'h0000_1020, 1'b1, "R5 before");
        flush(1'b1, 3'd0, 16, "R5");
        lookup(3'd0, 32'h0000_1000, 1'b0, "R5 cleared");
        lookup(3'd7, 32'h0000_1020, 1'b0, "R5 cleared");
        lookup(3'd5, 32'h0000_2000, 1'b0, "R5 cleared");
    endtask

    task automatic t_group_flush();
        cfg_grp_mode = 1'b1;
        fill(3'd1, 32'h0000_1000);
        fill(3'd1, 32'h0000_1020);
        fill(3'd2, 32'h0000_1000);
        flush(1'b0, 3'd1, 2, "R6");
        lookup(3'd1, 32'h0000_1000, 1'b0, "R6 set 1");
        lookup(3'd1, 32'h0000_1020, 1'b0, "R6 set 9");
        lookup(3'd2, 32'h0000_1000, 1'b1, "R6 other group kept");
    endtask

    task automatic t_flat_group_flush();
        cfg_grp_mode = 1'b0;
        flush(1'b1, 3'd0, 16, "R5");
        fill(3'd1, 32'h0000_1020);
        fill(3'd1, 32'h0000_1040);
        flush(1'b0, 3'd1, 2, "R10");
        lookup(3'd1, 32'h0000_1020, 1'b0, "R10 walked set");
        lookup(3'd1, 32'h0000_1040, 1'b1, "R10 survivor");
    endtask

    task automatic t_busy_blocks();
        int n;
        cfg_grp_mode = 1'b1;
        fill(3'd4, 32'h0000_1000);
        fl_valid = 1'b1; fl_all = 1'b1; fl_grp = 3'd0;
        @(posedge clk); @(negedge clk);
        fl_valid = 1'b0;
        n = 0;
        while (stall && n < 40) begin
            n++;
            chk("R7", "rsp_valid in stall", 64'(rsp_valid), 64'd0);
            lk_valid = 1'b1; lk_grp = 3'd4; lk_addr = 32'h0000_1000;
            fill_valid = 1'b1; fill_grp = 3'd6; fill_addr = 32'h0000_4000; fill_vec = vec_of(3'd6, 32'h0000_4000);
            fl_valid = 1'b1; fl_all = 1'b0; fl_grp = 3'd2;
            @(negedge clk);
        end
        lk_valid = 1'b0; fill_valid = 1'b0; fl_valid = 1'b0;
        chk("R7", "rsp_valid after last stall cycle", 64'(rsp_valid), 64'd0);
        chk("R9", "stall length with requests", 64'(n), 64'd16);
        lookup(3'd6, 32'h0000_4000, 1'b0, "R8 dropped fill");
        lookup(3'd4, 32'h0000_1000, 1'b0, "R5 flushed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_group_index();
        t_flat_index();
        t_same_cycle();
        t_full_flush();
        t_group_flush();
        t_flat_group_flush();
        t_busy_blocks();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule